// File: doc/BRIEF.md
# Presettable Binary Up-Counter with Dual Enables

This block is a synchronous binary up-counter, four bits wide by default, that can be preset from a parallel data input and cleared by an active-low reset. Counting needs two enables to be high together. The carry output is qualified by only one of those enables. Several stages can therefore be chained: each stage's carry drives the carry-qualifying enable of the next stage, and a shared enable holds the whole chain still.

Each stage follows a fixed priority: reset first, then preset load, then count, then hold. A build-time parameter sets how reset acts. In one variant the value clears as soon as reset goes low, without waiting for a clock edge. In the other variant reset is sampled on the rising clock edge like every other control. Load, count and synchronous clear all take effect on the rising edge.

Top module: `presettable_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `q` is all zeros after that edge, in both reset variants.
- R2: With `ASYNC_CLR` = 1, `q` becomes zero as soon as `rst_n` falls, before the next rising clock edge.
- R3: With `ASYNC_CLR` = 0, a falling `rst_n` leaves `q` unchanged until the next rising clock edge, and `q` is zero after that edge.
- R4: With `rst_n` high and `load_n` low, `q` takes the value of `din` at the rising edge, whatever the values of `en_p` and `en_t`.
- R5: When `rst_n` is low and `load_n` is low together, the clear wins and `q` becomes zero.
- R6: With `rst_n` and `load_n` high and both `en_p` and `en_t` high, `q` increases by one at each rising edge.
- R7: With `rst_n` and `load_n` high, `en_p` low and `en_t` high, `q` keeps its value across the edge.
- R8: With `rst_n` and `load_n` high, `en_t` low and `en_p` high, `q` keeps its value across the edge.
- R9: A count enabled while `q` is all ones (1111) wraps `q` to all zeros (0000) at the next edge.
- R10: `carry` is high exactly when `q` is all ones and `en_t` is high. `en_p` does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; actions happen on its rising edge |
| rst_n | input | 1 | Active-low clear; acts asynchronously or synchronously depending on `ASYNC_CLR` |
| load_n | input | 1 | Active-low preset strobe |
| din | input | W | Preset value |
| en_p | input | 1 | Count enable that does not qualify the carry |
| en_t | input | 1 | Count enable that also qualifies the carry |
| q | output | W | Counter value |
| carry | output | 1 | High when `q` is all ones and `en_t` is high |

## Verification
The bench drives every combination of the two enables, with load inactive, from a known preset. This separates a true increment from a hold caused by either enable, and shows that `load_n` overrides both enables. The counter is run through 1110, 1111 and 0000 with `en_p` toggled, so the carry is seen to follow `en_t` and the all-ones value only. Both reset variants are built side by side and fed the same stimulus. A reset dropped in the middle of a clock period shows the asynchronous build clearing at once while the synchronous build keeps its value until the edge. Reset and load are also asserted together to check priority.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int unsigned CNT_DEF_W = 4;

    // Action chosen for the next rising edge, in priority order.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } cnt_act_e;

    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic en_p;
        logic en_t;
    } cnt_ctrl_t;

    function automatic cnt_act_e pick_action(cnt_ctrl_t c);
        cnt_act_e a;
        if (!c.clr_n)
            a = ACT_CLEAR;
        else if (!c.load_n)
            a = ACT_LOAD;
        else if (c.en_p && c.en_t)
            a = ACT_COUNT;
        else
            a = ACT_HOLD;
        return a;
    endfunction

endpackage

// File: rtl/cnt_ctrl_decode.sv
module cnt_ctrl_decode
    import cnt_pkg::*;
(
    input  cnt_ctrl_t ctrl,
    output cnt_act_e  act
);
    always_comb begin
        act = pick_action(ctrl);
    end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
    import cnt_pkg::*;
#(
    parameter int unsigned W         = CNT_DEF_W,
    parameter bit          ASYNC_CLR = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_act_e     act,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;

    always_comb begin
        unique case (act)
            ACT_CLEAR: q_nxt = ZERO;
            ACT_LOAD:  q_nxt = din;
            ACT_COUNT: q_nxt = q_r + ONE;
            default:   q_nxt = q_r;
        endcase
    end

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q_r <= ZERO;
                else
                    q_r <= q_nxt;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                q_r <= q_nxt;
            end
        end
    endgenerate

    assign q = q_r;
endmodule

// File: rtl/cnt_carry_gen.sv
module cnt_carry_gen #(
    parameter int unsigned W = cnt_pkg::CNT_DEF_W
) (
    input  logic [W-1:0] q,
    input  logic         en_t,
    output logic         carry
);
    always_comb begin
        carry = en_t & (&q);
    end
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
    import cnt_pkg::*;
#(
    parameter int unsigned W         = CNT_DEF_W,
    parameter bit          ASYNC_CLR = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         en_p,
    input  logic         en_t,
    output logic [W-1:0] q,
    output logic         carry
);
    cnt_ctrl_t ctrl;
    cnt_act_e  act;

    always_comb begin
        ctrl.clr_n  = rst_n;
        ctrl.load_n = load_n;
        ctrl.en_p   = en_p;
        ctrl.en_t   = en_t;
    end

    cnt_ctrl_decode u_dec (
        .ctrl (ctrl),
        .act  (act)
    );

    cnt_state_reg #(.W(W), .ASYNC_CLR(ASYNC_CLR)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .din   (din),
        .q     (q)
    );

    cnt_carry_gen #(.W(W)) u_carry (
        .q     (q),
        .en_t  (en_t),
        .carry (carry)
    );
endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk #(
    parameter int unsigned W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_n,
    input logic [W-1:0] din,
    input logic         en_p,
    input logic         en_t,
    input logic [W-1:0] q,
    input logic         carry
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q == $past(din));  // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_p && en_t) |=> q == $past(q) + ONE);  // R6

    AST_HOLD_NO_ENP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_p) |=> $stable(q));  // R7

    AST_HOLD_NO_ENT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_t) |=> $stable(q));  // R8

    AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_t && (&q)) |-> carry);  // R10

    AST_CARRY_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (en_t && (&q)));  // R10
endmodule

bind presettable_counter presettable_counter_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_n (load_n),
    .din    (din),
    .en_p   (en_p),
    .en_t   (en_t),
    .q      (q),
    .carry  (carry)
);

// File: tb/presettable_counter_tb.sv
module presettable_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic [W-1:0] din = '0;
    logic         en_p = 1'b0;
    logic         en_t = 1'b0;
    logic [W-1:0] q_a, q_s;
    logic         carry_a, carry_s;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    presettable_counter #(.W(W), .ASYNC_CLR(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q_a), .carry(carry_a)
    );

    presettable_counter #(.W(W), .ASYNC_CLR(1'b0)) dut_s_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q_s), .carry(carry_s)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Wait for a rising edge, then step 1 time unit past it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ctl(input logic r, input logic l, input logic p, input logic t);
        rst_n = r; load_n = l; en_p = p; en_t = t;
    endtask

    task automatic preset(input logic [W-1:0] v);
        set_ctl(1, 0, 0, 0); din = v;
        tick();
        set_ctl(1, 1, 0, 0);
    endtask

    task automatic t_reset();
        set_ctl(0, 1, 1, 1);
        tick(); tick();
        check("R1 async q", q_a, 0);
        check("R1 sync q", q_s, 0);
        set_ctl(1, 1, 0, 0);
    endtask

    task automatic t_load();
        din = 4'hA; set_ctl(1, 0, 1, 1);
        tick();
        check("R4 load both enables", q_a, 10);
        check("R4 load sync", q_s, 10);
        din = 4'h5; set_ctl(1, 0, 0, 0);
        tick();
        check("R4 load no enables", q_a, 5);
        set_ctl(1, 1, 0, 0);
    endtask

    task automatic t_count_hold();
        preset(4'h3);
        set_ctl(1, 1, 1, 1);
        tick();
        check("R6 count 3->4", q_a, 4);
        tick();
        check("R6 count 4->5", q_s, 5);
        set_ctl(1, 1, 0, 1);
        tick(); tick();
        check("R7 hold en_p low", q_a, 5);
        set_ctl(1, 1, 1, 0);
        tick(); tick();
        check("R8 hold en_t low", q_a, 5);
        check("R8 hold en_t low sync", q_s, 5);
        set_ctl(1, 1, 0, 0);
        tick();
        check("R7 hold both low", q_a, 5);
    endtask

    task automatic t_wrap_carry();
        preset(4'hE);
        set_ctl(1, 1, 1, 1);
        #1;
        check("R10 no carry at 1110", carry_a, 0);
        tick();
        check("R6 count to 1111", q_a, 15);
        check("R10 carry at 1111", carry_a, 1);
        set_ctl(1, 1, 0, 1);
        #1;
        check("R10 carry ignores en_p", carry_a, 1);
        set_ctl(1, 1, 1, 0);
        #1;
        check("R10 carry needs en_t", carry_a, 0);
        set_ctl(1, 1, 1, 1);
        tick();
        check("R9 wrap to zero", q_a, 0);
        check("R9 wrap to zero sync", q_s, 0);
        check("R10 carry drops after wrap", carry_a, 0);
        set_ctl(1, 1, 0, 0);
    endtask

    task automatic t_priority();
        preset(4'h9);
        din = 4'h6; set_ctl(0, 0, 1, 1);
        tick();
        check("R5 clear beats load async", q_a, 0);
        check("R5 clear beats load sync", q_s, 0);
        set_ctl(1, 1, 0, 0);
    endtask

    task automatic t_variants();
        preset(4'hC);
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        check("R2 async clears mid-cycle", q_a, 0);
        check("R3 sync holds mid-cycle", q_s, 12);
        tick();
        check("R3 sync clears at edge", q_s, 0);
        check("R1 async stays clear", q_a, 0);
        set_ctl(1, 1, 0, 0);
    endtask

    initial begin
        t_reset();
        t_load();
        t_count_hold();
        t_wrap_carry();
        t_priority();
        t_variants();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule